// File: doc/BRIEF.md
# Timer Prescaler With Restart Synchronization

This block turns a generic clock into a one-cycle clock-enable strobe for a timer counter. A 3-bit code picks one of eight division ratios: 1, 2, 4, 8, 16, 64, 256 or 1024. The set skips 32 and 128. The counter that consumes the strobe is outside this block. It advances on the clock edge that ends each cycle in which the strobe is high.

The block also decides when a counter restart (a reload or a reset of the counter) is passed to the counter. A 2-bit sync code selects one of three options:
- apply the restart on the next generic clock edge;
- hold it until the next prescaled tick;
- apply it on the next generic clock edge and also clear the prescaler's own divider, so that the tick phase restarts with the counter.

A standby input halts the prescaler unless run-in-standby is set. Disabling the block clears its divider and drops any restart that is still waiting.

Top module: `tc_prescaler`

## Requirements
- R1: The ratio code N_sel selects a divide factor D: 0→1, 1→2, 2→4, 3→8, 4→16, 5→64, 6→256, 7→1024. The first tick after enabling comes in active cycle D-1, counting the first enabled cycle as 0.
- R2: While the block stays active, `tick_o` is high for exactly one cycle in every D active cycles. It fires when the internal count reaches D-1, and the count then returns to 0.
- R3: With ratio code 0, `tick_o` is high on every active cycle.
- R4: With sync code 0, `restart_o` is high in the same cycle as `restart_req_i` while the block is active. The tick phase is not disturbed.
- R5: With sync code 1, a restart request is held pending. `restart_o` is high only in a cycle where `tick_o` is high, and it is high for one such cycle per request.
- R6: With sync code 2, `restart_o` is high in the request cycle and the divider count is cleared. The next tick comes exactly D cycles after the restart cycle.
- R7: Sync code 3 behaves exactly as sync code 0.
- R8: A cycle is halted when `standby_i`=1 and `run_stby_i`=0. In a halted cycle, `tick_o` and `restart_o` are low, and the divider count and any pending restart are held. When the halt ends, counting resumes from the held count.
- R9: With `run_stby_i`=1, `standby_i` has no effect and ticks keep their normal period.
- R10: While `en_i`=0, `tick_o` and `restart_o` are low, the divider count is cleared and a pending restart is dropped.
- R11: After reset, the divider count is 0, nothing is pending, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Prescaler enable |
| standby_i | input | 1 | Standby indication |
| run_stby_i | input | 1 | Keep running in standby |
| ratio_sel_i | input | 3 | Divide ratio code |
| sync_sel_i | input | 2 | Restart alignment code |
| restart_req_i | input | 1 | Counter restart request |
| tick_o | output | 1 | Prescaled tick strobe, one cycle wide |
| restart_o | output | 1 | Restart-apply strobe for the counter |

## Verification
The bench sweeps all eight ratio codes and measures when the first tick comes, how many ticks fall in a window of three periods, and whether divide-by-one pulses every cycle. A wrong exponent mapping, for example one with a ratio of 32 in it, would shift the first tick and change the tick count. It then places restart requests at chosen phases in each sync mode:
- In mode 1, a design that did not hold the request would never apply it.
- In mode 2, a design that did not clear the divider would leave the tick at its old phase.
- A design that did not treat mode 3 as mode 0 would lose or delay the restart.

Standby with a pending request checks that the count and the request are frozen and not lost. Disabling with a pending request checks that a stale restart does not fire after the block is enabled again.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int SEL_W  = 3;
  localparam int SYNC_W = 2;
  localparam int CNT_W  = 10;

  typedef enum logic [SYNC_W-1:0] {
    SYNC_NOW   = 2'd0,
    SYNC_TICK  = 2'd1,
    SYNC_CLEAR = 2'd2,
    SYNC_RSVD  = 2'd3
  } sync_mode_e;

  // ratio exponent: codes 0..4 linear, then steps of two (64, 256, 1024)
  function automatic int ratio_exp(input logic [SEL_W-1:0] code);
    int c;
    c = int'(code);
    return (c < 5) ? c : (2 * c - 4);
  endfunction
endpackage

// File: rtl/psc_ratio_decode.sv
module psc_ratio_decode
  import psc_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic [SW-1:0] sel_i,
  output logic [CW-1:0] lim_o
);
  logic [31:0] one_hot;

  always_comb begin
    one_hot = 32'd1 << ratio_exp(sel_i);
    lim_o   = CW'(one_hot - 32'd1);
  end
endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          run_en_i,
  input  logic          clr_i,
  input  logic [CW-1:0] lim_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  // >= so that lowering the ratio mid-count still wraps
  assign wrap   = (cnt_q >= lim_i);
  assign tick_o = run_en_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                cnt_d = '0;
    else if (run_en_i) begin
      if (clr_i || wrap)      cnt_d = '0;
      else                    cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> (cnt_q == '0)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_en_i && clr_i) |=> (cnt_q == '0)); // R6
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_en_i) |=> $stable(cnt_q)); // R8
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/psc_restart_sync.sv
module psc_restart_sync
  import psc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              run_en_i,
  input  logic [SYNC_W-1:0] mode_i,
  input  logic              req_i,
  input  logic              tick_i,
  output logic              apply_o,
  output logic              clr_o
);
  sync_mode_e mode;
  logic       pend_q, want, aligned;

  assign mode = sync_mode_e'(mode_i);
  assign want = req_i || pend_q;

  always_comb begin
    case (mode)
      SYNC_TICK: aligned = tick_i;
      default:   aligned = 1'b1;   // NOW, CLEAR, reserved
    endcase
  end

  assign apply_o = run_en_i && want && aligned;
  assign clr_o   = apply_o && (mode == SYNC_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    pend_q <= 1'b0;
    else if (!en_i) pend_q <= 1'b0;
    else            pend_q <= want && !apply_o;

  AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q); // R10
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_q && !run_en_i) |=> pend_q); // R8
  AST_SYNC1_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_o && mode_i == 2'd1) |-> tick_i); // R5
  AST_APPLY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && apply_o) |=> !pend_q); // R5
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler
  import psc_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              standby_i,
  input  logic              run_stby_i,
  input  logic [SW-1:0]     ratio_sel_i,
  input  logic [SYNC_W-1:0] sync_sel_i,
  input  logic              restart_req_i,
  output logic              tick_o,
  output logic              restart_o
);
  logic          run_en, clr;
  logic [CW-1:0] lim;

  assign run_en = en_i && !(standby_i && !run_stby_i);

  psc_ratio_decode #(.SW(SW), .CW(CW)) u_dec (
    .sel_i (ratio_sel_i),
    .lim_o (lim)
  );

  psc_divider #(.CW(CW)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .run_en_i (run_en),
    .clr_i    (clr),
    .lim_i    (lim),
    .tick_o   (tick_o)
  );

  psc_restart_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .run_en_i (run_en),
    .mode_i   (sync_sel_i),
    .req_i    (restart_req_i),
    .tick_i   (tick_o),
    .apply_o  (restart_o),
    .clr_o    (clr)
  );

  AST_DIV1_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && ratio_sel_i == '0) |-> tick_o); // R3
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!tick_o && !restart_o)); // R10
endmodule

// File: tb/tb_tc_prescaler.sv
`timescale 1ns/1ps
module tb_tc_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, stby = 1'b0, rstby = 1'b0, req = 1'b0;
  logic [2:0] rsel = '0;
  logic [1:0] ssel = '0;
  logic       tick, rs;

  int total = 0, bad = 0;
  logic tk [0:4095];
  logic ra [0:4095];

  always #10 clk = ~clk;

  tc_prescaler dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .standby_i(stby),
    .run_stby_i(rstby), .ratio_sel_i(rsel), .sync_sel_i(ssel),
    .restart_req_i(req), .tick_o(tick), .restart_o(rs)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(input int code);
    case (code)
      0: return 1;    1: return 2;    2: return 4;    3: return 8;
      4: return 16;   5: return 64;   6: return 256;  default: return 1024;
    endcase
  endfunction

  // one disabled cycle, then len enabled cycles; request pulsed at req_at
  task automatic run(input int len, input int req_at);
    @(negedge clk); en = 1'b0; req = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      en  = 1'b1;
      req = (i == req_at);
      #1;
      tk[i] = tick; ra[i] = rs;
    end
    @(negedge clk); req = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first, cnt, d;
    req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 tick in reset", int'(tick), 0);
    chk("R11 restart in reset", int'(rs), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 tick after reset", int'(tick), 0);
    chk("R11 restart after reset", int'(rs), 0);
    req = 1'b0;

    // R1 R2 R3: ratio sweep
    for (int c = 0; c < 8; c++) begin
      rsel = c[2:0]; ssel = 2'd0;
      d = div_of(c);
      run(3 * d, -1);
      first = -1; cnt = 0;
      for (int i = 0; i < 3 * d; i++) if (tk[i]) begin
        cnt++;
        if (first < 0) first = i;
      end
      chk($sformatf("R1 first tick code %0d", c), first, d - 1);
      chk($sformatf("R2 ticks in 3 periods code %0d", c), cnt, 3);
      if (c == 0) chk("R3 div1 every cycle", cnt, 3);
    end

    // R4 and R7: immediate restart, phase kept
    for (int m = 0; m < 4; m += 3) begin
      rsel = 3'd3; ssel = m[1:0];
      run(10, 3);
      for (int i = 0; i < 10; i++) begin
        chk($sformatf("%s restart idx %0d", (m == 0) ? "R4" : "R7", i),
            int'(ra[i]), int'(i == 3));
        chk($sformatf("%s tick idx %0d", (m == 0) ? "R4" : "R7", i),
            int'(tk[i]), int'(i == 7));
      end
    end

    // R6: clear mode re-phases the divider (D=4, request at 5)
    rsel = 3'd2; ssel = 2'd2;
    run(11, 5);
    for (int i = 0; i < 11; i++) begin
      chk($sformatf("R6 restart idx %0d", i), int'(ra[i]), int'(i == 5));
      chk($sformatf("R6 tick idx %0d", i), int'(tk[i]), int'(i == 3 || i == 9));
    end

    // R5: tick-aligned restart (D=4, request at 4 -> applied at 7)
    rsel = 3'd2; ssel = 2'd1;
    run(12, 4);
    for (int i = 0; i < 12; i++)
      chk($sformatf("R5 restart idx %0d", i), int'(ra[i]), int'(i == 7));
    chk("R5 tick at apply", int'(tk[7]), 1);

    // R8: halt in standby with a pending restart (D=2, sync 1)
    rsel = 3'd1; ssel = 2'd1; rstby = 1'b0;
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; req = 1'b1; #1;
    chk("R8 idx0 tick", int'(tick), 0);
    chk("R8 idx0 restart", int'(rs), 0);
    for (int i = 1; i < 6; i++) begin
      @(negedge clk); req = 1'b0; stby = 1'b1; #1;
      chk($sformatf("R8 halted tick %0d", i), int'(tick), 0);
      chk($sformatf("R8 halted restart %0d", i), int'(rs), 0);
    end
    @(negedge clk); stby = 1'b0; #1;
    chk("R8 resume tick", int'(tick), 1);
    chk("R8 resume pending restart", int'(rs), 1);
    @(negedge clk); #1;
    chk("R8 after resume tick", int'(tick), 0);
    chk("R8 after resume restart", int'(rs), 0);

    // R9: run in standby
    rstby = 1'b1; stby = 1'b1; ssel = 2'd0;
    run(10, -1);
    cnt = 0;
    for (int i = 0; i < 10; i++) cnt += int'(tk[i]);
    chk("R9 ticks in standby", cnt, 5);
    chk("R9 first tick", int'(tk[1]), 1);
    stby = 1'b0; rstby = 1'b0;

    // R10: disable drops pending restart and clears count (D=4, sync 1)
    rsel = 3'd2; ssel = 2'd1;
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; req = 1'b1;
    @(negedge clk); req = 1'b0; en = 1'b0; #1;
    chk("R10 tick while off", int'(tick), 0);
    chk("R10 restart while off", int'(rs), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); en = 1'b1; #1;
      tk[i] = tick; ra[i] = rs;
    end
    for (int i = 0; i < 6; i++) begin
      chk($sformatf("R10 tick idx %0d", i), int'(tk[i]), int'(i == 3));
      chk($sformatf("R10 no stale restart idx %0d", i), int'(ra[i]), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule